// File: doc/BRIEF.md
# Chained Register Comparison Unit

This block watches four byte-wide registers, two accumulators (A0, A1) and two data registers (D0, D1), and keeps a set of status flags up to date on every cycle. It produces equal and less-than results for two comparator pairs and flags the value of each accumulator when it is all zeros or all ones. The first pair always compares A0 with D0. The operands of the second pair are chosen at run time: two stored pairing settings are held on the configuration inputs, and one dynamic select bit picks the setting in force.

Units of this kind are placed side by side to compare values wider than one byte. Each comparator pair has its own chain enable. When the enable is set, the pair combines its own result with the equal and less-than results from the next less significant unit. A more significant unit reads this unit's flag outputs as its own chain inputs, so a chain of several units ripples through. Every flag leaves the block twice: straight from the comparison logic, and again through a register one clock later.

Top module: `cmp_status_unit`

## Requirements
- R1: `flags_now[0]` is 1 when A0 equals D0, and `flags_now[1]` is 1 when A0 is less than D0 as an unsigned number (with chaining of pair 0 off).
- R2: `flags_now[2]` is 1 when A0 is 0x00, `flags_now[3]` when A0 is 0xFF, `flags_now[6]` when A1 is 0x00 and `flags_now[7]` when A1 is 0xFF.
- R3: The second pair gives equal on `flags_now[4]` and unsigned less-than on `flags_now[5]`. Its operands follow the 2-bit pairing code: 00 compares A0 with D1, 01 compares A1 with D1, 10 compares A1 with A0, and 11 compares A0 with itself, which always reads equal.
- R4: When `pair_dyn` is 0 the pairing code comes from `pair_cfg_a`. When it is 1 the code comes from `pair_cfg_b`.
- R5: With `chain_en0` at 1, pair 0 gives equal = own equal AND `chain_eq0_in`, and less-than = own less-than OR (own equal AND `chain_lt0_in`). A more significant unit chains from bits 0 and 1 of `flags_now`.
- R6: With `chain_en1` at 1, pair 1 combines its result with `chain_eq1_in` and `chain_lt1_in` by the same rule as R5. A more significant unit chains from bits 4 and 5.
- R7: While a pair's chain enable is 0, its incoming chain inputs have no effect on its flags.
- R8: `flags_reg` equals the value that `flags_now` had one clock cycle earlier.
- R9: A synchronous active-high `rst` clears `flags_reg` to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_a0 | input | 8 | Accumulator 0 value |
| reg_a1 | input | 8 | Accumulator 1 value |
| reg_d0 | input | 8 | Data register 0 value |
| reg_d1 | input | 8 | Data register 1 value |
| pair_cfg_a | input | 2 | Stored pairing code, setting A |
| pair_cfg_b | input | 2 | Stored pairing code, setting B |
| pair_dyn | input | 1 | Dynamic choice of pairing setting (1 = B) |
| chain_en0 | input | 1 | Chain enable for pair 0 |
| chain_en1 | input | 1 | Chain enable for pair 1 |
| chain_eq0_in | input | 1 | Equal from less significant unit, pair 0 |
| chain_lt0_in | input | 1 | Less-than from less significant unit, pair 0 |
| chain_eq1_in | input | 1 | Equal from less significant unit, pair 1 |
| chain_lt1_in | input | 1 | Less-than from less significant unit, pair 1 |
| flags_now | output | 8 | Unregistered flags, bit order per R1 to R3 |
| flags_reg | output | 8 | Registered flags, one cycle behind |

## Verification
The unregistered flags depend only on the present inputs, so the bench drives each stimulus on a falling edge and samples `flags_now` one time step later, before any rising edge. The registered flags are due at the first rising edge after the stimulus. The bench samples `flags_reg` on the following falling edge and compares it with the value expected for that same stimulus, before it drives the next one. The reset check samples `flags_reg` after a rising edge taken with `rst` high, while the inputs would give nonzero flags.

// File: rtl/cmp_status_pkg.sv
package cmp_status_pkg;

  typedef enum logic [1:0] {
    PAIR_A0_D1 = 2'b00,
    PAIR_A1_D1 = 2'b01,
    PAIR_A1_A0 = 2'b10,
    PAIR_A0_A0 = 2'b11
  } pair_sel_e;

  localparam int NUM_FLAGS = 8;
  localparam int F_EQ0   = 0;
  localparam int F_LT0   = 1;
  localparam int F_ZERO0 = 2;
  localparam int F_ONES0 = 3;
  localparam int F_EQ1   = 4;
  localparam int F_LT1   = 5;
  localparam int F_ZERO1 = 6;
  localparam int F_ONES1 = 7;

endpackage

// File: rtl/cmp_pair.sv
module cmp_pair #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  input  logic             chain_en,
  input  logic             eq_in,
  input  logic             lt_in,
  output logic             eq_out,
  output logic             lt_out
);

  logic own_eq;
  logic own_lt;

  assign own_eq = (lhs == rhs);
  assign own_lt = (lhs < rhs);

  always_comb begin
    if (chain_en) begin
      eq_out = own_eq & eq_in;
      lt_out = own_lt | (own_eq & lt_in);
    end else begin
      eq_out = own_eq;
      lt_out = own_lt;
    end
  end

  // R5 R6: a chained equal needs the incoming equal
  a_r5_eq_needs_incoming: assert property (@(posedge clk) disable iff (rst)
    (chain_en && eq_out) |-> eq_in);

  // R7: unchained less-than follows operands only
  a_r7_unchained_lt: assert property (@(posedge clk) disable iff (rst)
    !chain_en |-> (lt_out == (lhs < rhs)));

  // R5: with consistent inputs, equal and less-than never both set
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(eq_in && lt_in) |-> !(eq_out && lt_out));

endmodule

// File: rtl/cmp_detect.sv
module cmp_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] value,
  output logic             is_zero,
  output logic             is_ones
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  assign is_zero = (value == '0);
  assign is_ones = (value == ALL_ONES);

  // R2: both detectors never fire together
  a_r2_zero_ones_excl: assert property (@(posedge clk) disable iff (rst)
    !(is_zero && is_ones));

endmodule

// File: rtl/cmp_status_unit.sv
module cmp_status_unit
  import cmp_status_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WIDTH-1:0]     reg_a0,
  input  logic [WIDTH-1:0]     reg_a1,
  input  logic [WIDTH-1:0]     reg_d0,
  input  logic [WIDTH-1:0]     reg_d1,
  input  logic [1:0]           pair_cfg_a,
  input  logic [1:0]           pair_cfg_b,
  input  logic                 pair_dyn,
  input  logic                 chain_en0,
  input  logic                 chain_en1,
  input  logic                 chain_eq0_in,
  input  logic                 chain_lt0_in,
  input  logic                 chain_eq1_in,
  input  logic                 chain_lt1_in,
  output logic [NUM_FLAGS-1:0] flags_now,
  output logic [NUM_FLAGS-1:0] flags_reg
);

  localparam int NUM_ACC = 2;

  pair_sel_e        pair_active;
  logic [WIDTH-1:0] p1_lhs;
  logic [WIDTH-1:0] p1_rhs;
  logic [WIDTH-1:0] acc_val [NUM_ACC];
  logic             acc_zero [NUM_ACC];
  logic             acc_ones [NUM_ACC];
  logic             eq0, lt0, eq1, lt1;

  assign pair_active = pair_dyn ? pair_sel_e'(pair_cfg_b) : pair_sel_e'(pair_cfg_a);

  always_comb begin
    unique case (pair_active)
      PAIR_A0_D1: begin p1_lhs = reg_a0; p1_rhs = reg_d1; end
      PAIR_A1_D1: begin p1_lhs = reg_a1; p1_rhs = reg_d1; end
      PAIR_A1_A0: begin p1_lhs = reg_a1; p1_rhs = reg_a0; end
      default:    begin p1_lhs = reg_a0; p1_rhs = reg_a0; end
    endcase
  end

  cmp_pair #(.WIDTH(WIDTH)) u_pair0 (
    .clk(clk), .rst(rst), .lhs(reg_a0), .rhs(reg_d0),
    .chain_en(chain_en0), .eq_in(chain_eq0_in), .lt_in(chain_lt0_in),
    .eq_out(eq0), .lt_out(lt0)
  );

  cmp_pair #(.WIDTH(WIDTH)) u_pair1 (
    .clk(clk), .rst(rst), .lhs(p1_lhs), .rhs(p1_rhs),
    .chain_en(chain_en1), .eq_in(chain_eq1_in), .lt_in(chain_lt1_in),
    .eq_out(eq1), .lt_out(lt1)
  );

  assign acc_val[0] = reg_a0;
  assign acc_val[1] = reg_a1;

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_detect
    cmp_detect #(.WIDTH(WIDTH)) u_detect (
      .clk(clk), .rst(rst), .value(acc_val[k]),
      .is_zero(acc_zero[k]), .is_ones(acc_ones[k])
    );
  end

  always_comb begin
    flags_now          = '0;
    flags_now[F_EQ0]   = eq0;
    flags_now[F_LT0]   = lt0;
    flags_now[F_ZERO0] = acc_zero[0];
    flags_now[F_ONES0] = acc_ones[0];
    flags_now[F_EQ1]   = eq1;
    flags_now[F_LT1]   = lt1;
    flags_now[F_ZERO1] = acc_zero[1];
    flags_now[F_ONES1] = acc_ones[1];
  end

  always_ff @(posedge clk) begin
    if (rst) flags_reg <= '0;
    else     flags_reg <= flags_now;
  end

  // R8: registered flags lag by one cycle
  a_r8_reg_lag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags_reg == $past(flags_now)));

  // R9: reset clears registered flags
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (flags_reg == '0));

  // R1: unchained pair 0 equal follows A0 and D0
  a_r1_eq0_unchained: assert property (@(posedge clk) disable iff (rst)
    !chain_en0 |-> (flags_now[F_EQ0] == (reg_a0 == reg_d0)));

  // R3: self comparison always reads equal when unchained
  a_r3_self_equal: assert property (@(posedge clk) disable iff (rst)
    ((pair_active == PAIR_A0_A0) && !chain_en1) |-> (flags_now[F_EQ1] && !flags_now[F_LT1]));

endmodule

// File: tb/cmp_status_unit_tb.sv
module cmp_status_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [7:0] a0, a1, d0, d1;
    logic [1:0] sa, sb;
    logic       dyn, c0, c1;
    logic [3:0] cin;   // {eq0_in, lt0_in, eq1_in, lt1_in}
    logic [7:0] expf;
  } vec_t;

  // Expected flags bit order: [7]ones1 [6]zero1 [5]lt1 [4]eq1 [3]ones0 [2]zero0 [1]lt0 [0]eq0
  localparam vec_t VECS [NV] = '{
    '{8'd10,  8'd20,  8'd10,  8'd30, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 4'b0000, 8'h21}, // R1 R3 code 00
    '{8'd5,   8'd0,   8'd9,   8'd0,  2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 4'b0000, 8'h52}, // R2 R3 code 01
    '{8'hFF,  8'hFF,  8'h00,  8'd7,  2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 4'b0000, 8'h98}, // R4 setting B, code 10
    '{8'hFF,  8'hFF,  8'h00,  8'd7,  2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 4'b0000, 8'h88}, // R4 setting A
    '{8'd0,   8'd3,   8'd1,   8'd3,  2'b10, 2'b11, 1'b1, 1'b0, 1'b0, 4'b0000, 8'h16}, // R3 code 11
    '{8'd7,   8'd2,   8'd7,   8'd9,  2'b01, 2'b00, 1'b0, 1'b1, 1'b1, 4'b1001, 8'h21}, // R5 R6
    '{8'd7,   8'd9,   8'd7,   8'd9,  2'b01, 2'b00, 1'b0, 1'b1, 1'b1, 4'b0110, 8'h12}, // R5 R6
    '{8'd7,   8'd9,   8'd7,   8'd4,  2'b01, 2'b00, 1'b0, 1'b1, 1'b1, 4'b0011, 8'h00}, // R5 R6
    '{8'd3,   8'd4,   8'd4,   8'd4,  2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 4'b1111, 8'h12}, // R7
    '{8'd1,   8'd5,   8'd2,   8'd3,  2'b01, 2'b00, 1'b0, 1'b1, 1'b1, 4'b0011, 8'h02}, // R5 R6
    '{8'd0,   8'hFF,  8'd0,   8'd0,  2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4'b0000, 8'h95}, // R1 R2 R3
    '{8'hFE,  8'd0,   8'hFF,  8'd0,  2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 4'b0000, 8'h62}  // R1 R3 boundary
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] reg_a0, reg_a1, reg_d0, reg_d1;
  logic [1:0] pair_cfg_a, pair_cfg_b;
  logic       pair_dyn, chain_en0, chain_en1;
  logic       chain_eq0_in, chain_lt0_in, chain_eq1_in, chain_lt1_in;
  logic [7:0] flags_now, flags_reg;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_status_unit #(.WIDTH(8)) u_dut (
    .clk(clk), .rst(rst),
    .reg_a0(reg_a0), .reg_a1(reg_a1), .reg_d0(reg_d0), .reg_d1(reg_d1),
    .pair_cfg_a(pair_cfg_a), .pair_cfg_b(pair_cfg_b), .pair_dyn(pair_dyn),
    .chain_en0(chain_en0), .chain_en1(chain_en1),
    .chain_eq0_in(chain_eq0_in), .chain_lt0_in(chain_lt0_in),
    .chain_eq1_in(chain_eq1_in), .chain_lt1_in(chain_lt1_in),
    .flags_now(flags_now), .flags_reg(flags_reg)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    reg_a0 = v.a0; reg_a1 = v.a1; reg_d0 = v.d0; reg_d1 = v.d1;
    pair_cfg_a = v.sa; pair_cfg_b = v.sb; pair_dyn = v.dyn;
    chain_en0 = v.c0; chain_en1 = v.c1;
    {chain_eq0_in, chain_lt0_in, chain_eq1_in, chain_lt1_in} = v.cin;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    apply(VECS[0]);
    @(posedge clk);
    @(negedge clk);
    check("R9 reset state", flags_reg, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      #1;
      check($sformatf("vector %0d flags_now (R1-related tags per table)", i), flags_now, VECS[i].expf);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R8 vector %0d flags_reg", i), flags_reg, VECS[i].expf);
    end

    // R7: toggle chain inputs while chaining is off; flags must hold
    apply(VECS[8]);
    {chain_eq0_in, chain_lt0_in, chain_eq1_in, chain_lt1_in} = 4'b0000;
    #1;
    check("R7 chain inputs ignored", flags_now, 8'h12);

    // R5: ripple from a lower unit's own flags (lower byte A0<D0)
    apply(VECS[5]);
    chain_eq0_in = 1'b0; chain_lt0_in = 1'b1;
    #1;
    check("R5 ripple less-than", flags_now, 8'h22);

    // R8: registered output must not follow a change until the edge
    apply(VECS[10]);
    @(posedge clk);
    @(negedge clk);
    apply(VECS[11]);
    #1;
    check("R8 no early update", flags_reg, 8'h95);
    @(posedge clk);
    @(negedge clk);
    check("R8 update after edge", flags_reg, 8'h62);

    // R9: reset mid-run with nonzero flags
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 reset clears", flags_reg, 8'h00);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule